// File: doc/BRIEF.md
# Paged Byte-Write Engine for a Parallel Nonvolatile Memory

This block is a cycle-level model of the write path of a byte-wide nonvolatile memory. The host drives it over a plain parallel bus with active-low chip select, read strobe and write strobe, all sampled on the clock. Byte loads that land in one page are gathered in a page buffer. Each accepted load restarts a load window. When the window runs out with no new load, the engine enters a self-timed programming period. During that period it copies the buffered bytes into the storage array.

During programming the array cannot be read. Any read returns a status byte instead. Its top bit is the inverse of the top bit of the last byte loaded, and its next bit flips after every completed read. Software can poll either bit to find the end of programming. After programming, reads return array contents again. Until then, loads stay invisible to reads.

Top module: `eep_page_writer`

## Requirements
- R1: A byte load occurs only for a pulse during which `ce_n` and `we_n` are both low while `oe_n` is high. A pulse with `oe_n` low, or one with `we_n` low while `ce_n` stays high, loads nothing.
- R2: The load address is the `addr` value in the first cycle both strobes are low, so it is taken when the later of the two falls. The load data is the `din` value in the last such cycle, so it is taken before the earlier of the two rises.
- R3: The page number is `addr[ADDR_W-1:6]` and the byte offset is `addr[5:0]`, giving 64 bytes per page. Once a load has been accepted, a load to a different page is ignored and does not restart the load window.
- R4: Programming starts exactly `LOAD_WIN_CYC` clock edges after the edge that ends the most recent accepted load, unless an accepted load starts first. There is no limit on how long a chain of accepted loads may run.
- R5: Programming lasts `PROG_CYC` edges and then writes every loaded byte into the array. A later load to the same offset replaces the earlier one. Bytes that were not loaded keep their values.
- R6: During programming, a read at any address returns the status byte. Bit 7 is the inverse of bit 7 of the last accepted byte, bit 6 is the toggle bit, and bits 5:0 equal bits 5:0 of that byte.
- R7: The toggle bit is 0 when programming starts and flips once after each completed read during programming. After programming, repeated reads return the same array data.
- R8: Write pulses that start during programming are ignored.
- R9: `dout_en` is high only when `ce_n` and `oe_n` are both low. `dout` is zero whenever `dout_en` is low. Outside programming, `dout` shows the array byte at `addr` in the same cycle.
- R10: After reset the engine is idle, every array byte reads 8'hFF, and `dout_en` is low.
- R11: Loaded bytes are not visible to reads before programming ends; the array keeps its old contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ce_n | input | 1 | Chip select, active low |
| oe_n | input | 1 | Read strobe, active low |
| we_n | input | 1 | Write strobe, active low |
| addr | input | ADDR_W (10) | Byte address; upper bits give the page |
| din | input | 8 | Write data |
| dout | output | 8 | Read data or status byte, zero when not driven |
| dout_en | output | 1 | High while the read data is valid |

## Verification
Read data and `dout_en` are combinational, so the bench samples them 1 ns after the falling edge in the same cycle it sets up a read. A load takes effect at the edge that follows the strobe release. Programming begins `LOAD_WIN_CYC` edges after that edge and ends `PROG_CYC` edges later. The toggle bit flips at the edge after the read strobe is released. The bench counts rising edges from reset and waits for the exact edge index each of these events is due, checking one edge before and at the expiry point of the load window.

// File: rtl/eep_pkg.sv
package eep_pkg;

  localparam int EEP_DATA_W = 8;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LOAD = 2'd1,
    ST_PROG = 2'd2
  } eep_state_e;

  // Byte shown on reads while the array is busy programming.
  function automatic logic [EEP_DATA_W-1:0] status_byte(
    input logic [EEP_DATA_W-1:0] last_byte,
    input logic                  toggle
  );
    return {~last_byte[EEP_DATA_W-1], toggle, last_byte[EEP_DATA_W-3:0]};
  endfunction

endpackage

// File: rtl/eep_bus_qualifier.sv
module eep_bus_qualifier import eep_pkg::*; #(
  parameter int PAGE_W = 6
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  ce_n,
  input  logic                  oe_n,
  input  logic                  we_n,
  input  logic [PAGE_W-1:0]     addr_off,
  input  logic [EEP_DATA_W-1:0] din,
  output logic                  wr_start,
  output logic                  wr_end,
  output logic                  wr_busy,
  output logic [PAGE_W-1:0]     wr_off,
  output logic [EEP_DATA_W-1:0] wr_data,
  output logic                  rd_active,
  output logic                  rd_end
);

  logic wr_act;
  logic wr_act_q;
  logic rd_act_q;

  always_comb begin
    wr_act    = !ce_n && !we_n && oe_n;
    rd_active = !ce_n && !oe_n;
    wr_start  = wr_act && !wr_act_q;
    wr_end    = !wr_act && wr_act_q;
    rd_end    = !rd_active && rd_act_q;
    wr_busy   = wr_act_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_act_q <= 1'b0;
      rd_act_q <= 1'b0;
      wr_off   <= '0;
      wr_data  <= '0;
    end else begin
      wr_act_q <= wr_act;
      rd_act_q <= rd_active;
      if (wr_start) wr_off <= addr_off;
      if (wr_act) wr_data <= din;
    end
  end

endmodule

// File: rtl/eep_write_ctrl.sv
module eep_write_ctrl import eep_pkg::*; #(
  parameter int ADDR_W       = 10,
  parameter int PAGE_W       = 6,
  parameter int LOAD_WIN_CYC = 8,
  parameter int PROG_CYC     = 80
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_start,
  input  logic                     wr_end,
  input  logic                     wr_busy,
  input  logic                     rd_end,
  input  logic [ADDR_W-PAGE_W-1:0] addr_page,
  input  logic [EEP_DATA_W-1:0]    wr_data,
  output logic                     prog_active,
  output logic [ADDR_W-PAGE_W-1:0] page_q,
  output logic [EEP_DATA_W-1:0]    last_data,
  output logic                     tgl,
  output logic                     load_accept,
  output logic                     load_commit,
  output logic                     window_expired,
  output logic                     prog_done,
  output logic                     commit_en,
  output logic [PAGE_W-1:0]        commit_idx
);

  localparam int PAGE_SIZE  = 1 << PAGE_W;
  localparam int WIN_CNT_W  = $clog2(LOAD_WIN_CYC + 1);
  localparam int PROG_RAW_W = $clog2(PROG_CYC + 1);
  localparam int PROG_CNT_W = (PROG_RAW_W > PAGE_W) ? PROG_RAW_W : PAGE_W + 1;

  eep_state_e            state;
  logic                  acc_q;
  logic                  hold;
  logic [WIN_CNT_W-1:0]  win_cnt;
  logic [PROG_CNT_W-1:0] prog_cnt;

  always_comb begin
    prog_active    = (state == ST_PROG);
    load_accept    = wr_start && ((state == ST_IDLE) ||
                                  ((state == ST_LOAD) && (addr_page == page_q)));
    load_commit    = wr_end && acc_q;
    hold           = wr_busy && acc_q;
    window_expired = (state == ST_LOAD) && !load_accept && !hold &&
                     (win_cnt == WIN_CNT_W'(LOAD_WIN_CYC - 1));
    prog_done      = prog_active && (prog_cnt == PROG_CNT_W'(PROG_CYC - 1));
    commit_en      = prog_active && (32'(prog_cnt) < PAGE_SIZE);
    commit_idx     = prog_cnt[PAGE_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      acc_q     <= 1'b0;
      win_cnt   <= '0;
      prog_cnt  <= '0;
      page_q    <= '0;
      last_data <= '0;
      tgl       <= 1'b0;
    end else begin
      if (wr_start) acc_q <= load_accept;
      if (load_commit) last_data <= wr_data;
      unique case (state)
        ST_IDLE: begin
          if (load_accept) begin
            state   <= ST_LOAD;
            page_q  <= addr_page;
            win_cnt <= '0;
          end
        end
        ST_LOAD: begin
          if (load_accept || load_commit) begin
            win_cnt <= '0;
          end else if (hold) begin
            win_cnt <= win_cnt;
          end else if (window_expired) begin
            state    <= ST_PROG;
            prog_cnt <= '0;
            tgl      <= 1'b0;
          end else begin
            win_cnt <= win_cnt + 1'b1;
          end
        end
        ST_PROG: begin
          if (rd_end) tgl <= ~tgl;
          if (prog_done) state <= ST_IDLE;
          else prog_cnt <= prog_cnt + 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/eep_page_store.sv
module eep_page_store import eep_pkg::*; #(
  parameter int ADDR_W = 10,
  parameter int PAGE_W = 6
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     load_commit,
  input  logic [PAGE_W-1:0]        load_off,
  input  logic [EEP_DATA_W-1:0]    load_data,
  input  logic                     commit_en,
  input  logic [PAGE_W-1:0]        commit_idx,
  input  logic [ADDR_W-PAGE_W-1:0] page,
  input  logic                     prog_done,
  input  logic [ADDR_W-1:0]        rd_addr,
  output logic [EEP_DATA_W-1:0]    rd_data
);

  localparam int PAGE_SIZE = 1 << PAGE_W;
  localparam int DEPTH     = 1 << ADDR_W;

  logic [EEP_DATA_W-1:0] page_buf [PAGE_SIZE];
  logic [PAGE_SIZE-1:0]  valid;
  logic [EEP_DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (load_commit) page_buf[load_off] <= load_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid <= '0;
    end else if (prog_done) begin
      valid <= '0;
    end else if (load_commit) begin
      valid[load_off] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '1;
    end else if (commit_en && valid[commit_idx]) begin
      mem[{page, commit_idx}] <= page_buf[commit_idx];
    end
  end

  assign rd_data = mem[rd_addr];

endmodule

// File: rtl/eep_page_writer.sv
module eep_page_writer import eep_pkg::*; #(
  parameter int ADDR_W       = 10,
  parameter int PAGE_W       = 6,
  parameter int LOAD_WIN_CYC = 8,
  parameter int PROG_CYC     = 80
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  ce_n,
  input  logic                  oe_n,
  input  logic                  we_n,
  input  logic [ADDR_W-1:0]     addr,
  input  logic [EEP_DATA_W-1:0] din,
  output logic [EEP_DATA_W-1:0] dout,
  output logic                  dout_en
);

  localparam int PAGE_NUM_W = ADDR_W - PAGE_W;

  logic                  wr_start, wr_end, wr_busy, rd_active, rd_end;
  logic [PAGE_W-1:0]     wr_off;
  logic [EEP_DATA_W-1:0] wr_data;
  logic                  prog_active, tgl, load_accept, load_commit;
  logic                  window_expired, prog_done, commit_en;
  logic [PAGE_W-1:0]     commit_idx;
  logic [PAGE_NUM_W-1:0] page_q;
  logic [EEP_DATA_W-1:0] last_data;
  logic [EEP_DATA_W-1:0] array_data;

  eep_bus_qualifier #(.PAGE_W(PAGE_W)) i_qual (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
    .addr_off(addr[PAGE_W-1:0]), .din(din),
    .wr_start(wr_start), .wr_end(wr_end), .wr_busy(wr_busy),
    .wr_off(wr_off), .wr_data(wr_data),
    .rd_active(rd_active), .rd_end(rd_end)
  );

  eep_write_ctrl #(
    .ADDR_W(ADDR_W), .PAGE_W(PAGE_W),
    .LOAD_WIN_CYC(LOAD_WIN_CYC), .PROG_CYC(PROG_CYC)
  ) i_ctrl (
    .clk(clk), .rst_n(rst_n),
    .wr_start(wr_start), .wr_end(wr_end), .wr_busy(wr_busy), .rd_end(rd_end),
    .addr_page(addr[ADDR_W-1:PAGE_W]), .wr_data(wr_data),
    .prog_active(prog_active), .page_q(page_q), .last_data(last_data),
    .tgl(tgl), .load_accept(load_accept), .load_commit(load_commit),
    .window_expired(window_expired), .prog_done(prog_done),
    .commit_en(commit_en), .commit_idx(commit_idx)
  );

  eep_page_store #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) i_store (
    .clk(clk), .rst_n(rst_n),
    .load_commit(load_commit), .load_off(wr_off), .load_data(wr_data),
    .commit_en(commit_en), .commit_idx(commit_idx), .page(page_q),
    .prog_done(prog_done), .rd_addr(addr), .rd_data(array_data)
  );

  always_comb begin
    dout_en = rd_active;
    if (!rd_active)      dout = '0;
    else if (prog_active) dout = status_byte(last_data, tgl);
    else                  dout = array_data;
  end

endmodule

// File: rtl/eep_page_writer_chk.sv
module eep_page_writer_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       dout_en,
  input logic [7:0] dout,
  input logic       prog_active,
  input logic       load_accept,
  input logic       window_expired,
  input logic       prog_done,
  input logic       rd_end,
  input logic       tgl,
  input logic [7:0] last_data
);

  a_r9_quiet_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    !dout_en |-> (dout == 8'h00));

  a_r8_no_load_in_prog: assert property (@(posedge clk) disable iff (!rst_n)
    prog_active |-> !load_accept);

  a_r4_prog_after_expiry: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(prog_active) |-> $past(window_expired));

  a_r5_prog_ends_on_count: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(prog_active) |-> $past(prog_done));

  a_r7_toggle_per_read: assert property (@(posedge clk) disable iff (!rst_n)
    (prog_active && rd_end) |=> (tgl != $past(tgl)));

  a_r6_status_bits: assert property (@(posedge clk) disable iff (!rst_n)
    (prog_active && dout_en) |-> ((dout[7] != last_data[7]) && (dout[6] == tgl)));

endmodule

bind eep_page_writer eep_page_writer_chk i_chk (
  .clk(clk), .rst_n(rst_n), .dout_en(dout_en), .dout(dout),
  .prog_active(prog_active), .load_accept(load_accept),
  .window_expired(window_expired), .prog_done(prog_done),
  .rd_end(rd_end), .tgl(tgl), .last_data(last_data)
);

// File: tb/test_eep_page_writer.sv
module test_eep_page_writer;

  localparam int W = 8;
  localparam int P = 80;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1;
  logic [9:0] addr = '0;
  logic [7:0] din = '0;
  logic [7:0] dout;
  logic       dout_en;

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;
  bit done = 1'b0;

  logic [7:0] mdl   [1024];
  logic [7:0] stage [1024];

  // {accepted, address, data}
  localparam logic [18:0] VEC [7] = '{
    {1'b1, 10'h080, 8'h3C},
    {1'b1, 10'h081, 8'hA5},
    {1'b1, 10'h085, 8'h0F},
    {1'b0, 10'h0C2, 8'h77},
    {1'b1, 10'h0BF, 8'h81},
    {1'b1, 10'h085, 8'hE1},
    {1'b1, 10'h08A, 8'h5A}
  };

  eep_page_writer #(.ADDR_W(10), .PAGE_W(6), .LOAD_WIN_CYC(W), .PROG_CYC(P)) i_eep_page_writer (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
    .addr(addr), .din(din), .dout(dout), .dout_en(dout_en)
  );

  always #2 clk = ~clk;

  always @(posedge clk) begin
    if (!rst_n) cyc <= 0;
    else cyc <= cyc + 1;
  end

  function automatic logic [7:0] exp_status(input logic [7:0] d, input logic t);
    logic [7:0] r;
    r = (d ^ 8'h80) & 8'hBF;
    if (t) r = r | 8'h40;
    return r;
  endfunction

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic do_write(input logic [9:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; din = d; ce_n = 1'b0; we_n = 1'b0; oe_n = 1'b1;
    @(negedge clk);
    @(negedge clk);
    we_n = 1'b1;
    @(negedge clk);
    ce_n = 1'b1;
  endtask

  task automatic do_read(input logic [9:0] a, output logic [7:0] d);
    @(negedge clk);
    addr = a; ce_n = 1'b0; oe_n = 1'b0;
    #1 d = dout;
    @(negedge clk);
    oe_n = 1'b1; ce_n = 1'b1;
  endtask

  task automatic wait_until(input int n);
    while (cyc < n) @(negedge clk);
  endtask

  task automatic read_check(input string tag, input logic [9:0] a, input logic [7:0] exp);
    logic [7:0] d;
    do_read(a, d);
    check(tag, d, exp);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    int k;
    logic [7:0] d, d2, last;
    for (int i = 0; i < 1024; i++) begin mdl[i] = 8'hFF; stage[i] = 8'hFF; end

    repeat (3) @(negedge clk);
    #1 check("R10 dout_en in reset", {7'd0, dout_en}, 8'h00);
    rst_n = 1'b1;

    // R10 / R9 reset state and output gating
    @(negedge clk);
    ce_n = 1'b0; oe_n = 1'b1;
    #1 check("R9 oe_n high disables", {7'd0, dout_en}, 8'h00);
    check("R9 dout zero when off", dout, 8'h00);
    ce_n = 1'b1; oe_n = 1'b0;
    #1 check("R9 ce_n high disables", {7'd0, dout_en}, 8'h00);
    oe_n = 1'b1;
    read_check("R10 erased low", 10'h000, 8'hFF);
    read_check("R10 erased high", 10'h3FF, 8'hFF);

    // Table-driven page load (R3, R5)
    last = 8'h00;
    for (int i = 0; i < 7; i++) begin
      do_write(VEC[i][17:8], VEC[i][7:0]);
      if (VEC[i][18]) begin
        stage[VEC[i][17:8]] = VEC[i][7:0];
        last = VEC[i][7:0];
      end
    end
    k = cyc;
    read_check("R11 load not visible", 10'h080, 8'hFF);
    wait_until(k + W);
    read_check("R6 status any address", 10'h123, exp_status(last, 1'b0));
    do_read(10'h080, d);
    check("R7 toggle after one read", d, exp_status(last, 1'b1));
    do_read(10'h080, d);
    check("R7 toggle after two reads", d, exp_status(last, 1'b0));
    do_write(10'h081, 8'h99);
    do_write(10'h300, 8'h42);
    wait_until(k + W + P);
    for (int i = 0; i < 1024; i++) mdl[i] = stage[i];
    for (int i = 0; i < 7; i++)
      read_check("R5 page readback", VEC[i][17:8], mdl[VEC[i][17:8]]);
    read_check("R5 unloaded byte kept", 10'h082, 8'hFF);
    read_check("R3 other page ignored", 10'h0C2, 8'hFF);
    read_check("R8 write in prog ignored", 10'h081, 8'hA5);
    read_check("R8 new page in prog ignored", 10'h300, 8'hFF);
    do_read(10'h0BF, d);
    do_read(10'h0BF, d2);
    check("R7 no toggle after prog", d2, d);

    // R1 / R2 qualification and capture points, page 4
    @(negedge clk);
    addr = 10'h100; din = 8'h11; ce_n = 1'b0; we_n = 1'b0; oe_n = 1'b1;
    @(negedge clk);
    addr = 10'h105; din = 8'h22;
    @(negedge clk);
    we_n = 1'b1;
    @(negedge clk);
    ce_n = 1'b1;
    @(negedge clk);
    we_n = 1'b0; ce_n = 1'b1; addr = 10'h110; din = 8'h33;
    @(negedge clk);
    ce_n = 1'b0; addr = 10'h111;
    @(negedge clk);
    @(negedge clk);
    ce_n = 1'b1;
    @(negedge clk);
    we_n = 1'b1;
    k = cyc;
    @(negedge clk);
    addr = 10'h112; din = 8'h44; ce_n = 1'b0; we_n = 1'b0; oe_n = 1'b0;
    @(negedge clk);
    @(negedge clk);
    ce_n = 1'b1; we_n = 1'b1; oe_n = 1'b1;
    @(negedge clk);
    addr = 10'h113; din = 8'h55; we_n = 1'b0;
    @(negedge clk);
    @(negedge clk);
    we_n = 1'b1;
    wait_until(k + W + P);
    read_check("R2 data at last cycle, addr at start", 10'h100, 8'h22);
    read_check("R2 late address not used", 10'h105, 8'hFF);
    read_check("R2 addr taken when ce_n falls", 10'h111, 8'h33);
    read_check("R2 addr before ce_n fall unused", 10'h110, 8'hFF);
    read_check("R1 oe_n low blocks load", 10'h112, 8'hFF);
    read_check("R1 ce_n high blocks load", 10'h113, 8'hFF);

    // R4 window chaining and mismatched page, page 5
    for (int i = 0; i < 5; i++) begin
      if (i != 0) repeat (W - 3) @(negedge clk);
      do_write(10'h140 + 10'(i), 8'h60 + 8'(i));
    end
    k = cyc;
    do_write(10'h1A0, 8'h77);
    @(negedge clk);
    addr = 10'h150; ce_n = 1'b0; oe_n = 1'b0;
    wait_until(k + W - 1);
    #1 check("R4 one edge before expiry", dout, 8'hFF);
    @(negedge clk);
    #1 check("R4 R3 expiry not restarted", dout, exp_status(8'h64, 1'b0));
    ce_n = 1'b1; oe_n = 1'b1;
    wait_until(k + W + P);
    for (int i = 0; i < 5; i++)
      read_check("R4 chained loads kept", 10'h140 + 10'(i), 8'h60 + 8'(i));
    read_check("R3 mismatched page ignored", 10'h1A0, 8'hFF);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule